// File: doc/BRIEF.md
# Active-Window Pixel Crossing FIFO

This block takes a pixel stream in the pixel clock domain and keeps only the samples that fall inside the visible picture, meaning the sample is inside both the viewable part of the line and the viewable part of the field. Those samples go into a 512-entry, 20-bit FIFO. A consumer empties the FIFO on its own read clock, which has no phase or frequency relation to the pixel clock. Blanking samples never enter the FIFO. The output word is always the full 20-bit pixel, and this block cannot produce a narrower output.

The block also drives two plain indicator outputs. One shows that the current line is in its viewable portion and the other shows that the current field is in its viewable portion. Both are registered copies of the incoming activity flags. Write and read pointers cross between the clock domains as Gray codes through two-flop synchronizers, so each side sees a view of the other side that is late but safe. Back-pressure works as follows. The producer side has no ready signal. A viewable sample offered while `wr_full` is high is lost, and the loss is recorded in a sticky flag. The consumer may raise `rd_pop` at any time, but a pop is acted on only while `rd_empty` is low. A pop while empty is ignored.

Top module: `active_pixel_cdc_fifo`

## Requirements
- R1: Accepted pixels come out on `rd_data` in the order they were written, with all 20 bits intact. The FIFO holds up to 512 words.
- R2: A sample is written only on a `wclk` edge where `pix_valid`, `pix_hact` and `pix_vact` are all 1. Any sample with `pix_hact`=0 or `pix_vact`=0 is discarded and never appears at the read side.
- R3: A viewable sample offered while `wr_full` is 1 is dropped. It does not overwrite any stored word, and `wr_full` stays 1.
- R4: `wr_overflow` becomes 1 on the `wclk` edge that drops a sample under R3. It then stays 1 until `wrst_n` is asserted, even after the FIFO drains.
- R5: With no reads, `wr_full` is 0 after 511 accepted writes and 1 right after the edge of the 512th accepted write.
- R6: After a write, `rd_empty` falls within a few `rclk` cycles, once the write pointer has passed through the synchronizer.
- R7: A pop while `rd_empty`=1 leaves the read pointer unchanged and holds `rd_data` at its last value.
- R8: On an `rclk` edge with `rd_pop`=1 and `rd_empty`=0, `rd_data` loads the oldest stored word. After the edge that pops the last stored word, `rd_empty` is 1.
- R9: `line_active` and `field_active` equal `pix_hact` and `pix_vact` as sampled on the previous `wclk` edge.
- R10: After reset, `rd_empty`=1, `wr_full`=0, `wr_overflow`=0, `rd_data`=0, and both activity outputs are 0.
- R11: Once a full FIFO is popped, `wr_full` returns to 0 within a few `wclk` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Pixel (write) clock |
| wrst_n | input | 1 | Asynchronous active-low reset, write domain |
| pix_data | input | 20 | Pixel word |
| pix_valid | input | 1 | Pixel word present this cycle |
| pix_hact | input | 1 | Sample lies in the viewable part of the line |
| pix_vact | input | 1 | Sample lies in the viewable part of the field |
| line_active | output | 1 | Registered line activity indicator |
| field_active | output | 1 | Registered field activity indicator |
| wr_full | output | 1 | FIFO full, as seen from the write side |
| wr_overflow | output | 1 | Sticky flag: a viewable sample was dropped |
| rclk | input | 1 | Consumer (read) clock |
| rrst_n | input | 1 | Asynchronous active-low reset, read domain |
| rd_pop | input | 1 | Consumer takes one word |
| rd_data | output | 20 | Last popped word |
| rd_empty | output | 1 | FIFO empty, as seen from the read side |

## Verification
The embedded assertions check the following on every cycle:
- Each Gray pointer changes by at most one bit per clock.
- The write pointer stays put when a sample is outside the visible window or the FIFO is full.
- The overflow flag rises only on a dropped viewable sample and never falls.
- A pop while empty moves neither the read pointer nor `rd_data`.

Data ordering, the exact full and empty thresholds, the delay through the synchronizers, and the filtering of blanking samples can only be shown by the bench scenarios. Those scenarios push known patterns across the two clocks and compare what comes out.

// File: rtl/apf_pkg.sv
package apf_pkg;
  // number of flops in each pointer synchronizer
  parameter int unsigned APF_SYNC_STAGES = 2;
endpackage

// File: rtl/apf_sync.sv
module apf_sync
  import apf_pkg::*;
#(
  parameter int unsigned W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [APF_SYNC_STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < APF_SYNC_STAGES; k++) stg[k] <= '0;
    end else begin
      stg[0] <= d;
      for (int k = 1; k < APF_SYNC_STAGES; k++) stg[k] <= stg[k-1];
    end
  end

  assign q = stg[APF_SYNC_STAGES-1];
endmodule

// File: rtl/apf_store.sv
module apf_store #(
  parameter int unsigned PIX_W = 20,
  parameter int unsigned AW    = 9
) (
  input  logic             wclk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [PIX_W-1:0] wdata,
  input  logic             rclk,
  input  logic             rrst_n,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [PIX_W-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [PIX_W-1:0] cells [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) cells[waddr] <= wdata;
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) rdata <= '0;
    else if (re) rdata <= cells[raddr];
  end

  // R7: output word only moves on an accepted pop
  p_rdata_hold_r7: assert property (@(posedge rclk) disable iff (!rrst_n)
    !re |=> $stable(rdata));
endmodule

// File: rtl/apf_wr_side.sv
module apf_wr_side #(
  parameter int unsigned AW = 9
) (
  input  logic          wclk,
  input  logic          wrst_n,
  input  logic          pix_valid,
  input  logic          pix_hact,
  input  logic          pix_vact,
  input  logic [AW:0]   rgray_sync,
  output logic          push,
  output logic [AW-1:0] waddr,
  output logic [AW:0]   wgray,
  output logic          full,
  output logic          overflow
);
  logic          offer;
  logic [AW:0]   wbin, wbin_nx, wgray_nx;
  logic [AW:0]   full_pat;
  logic          full_nx;

  assign offer    = pix_valid & pix_hact & pix_vact;
  assign push     = offer & ~full;
  assign wbin_nx  = wbin + {{AW{1'b0}}, push};
  assign wgray_nx = (wbin_nx >> 1) ^ wbin_nx;
  assign full_pat = {~rgray_sync[AW:AW-1], rgray_sync[AW-2:0]};
  assign full_nx  = (wgray_nx == full_pat);
  assign waddr    = wbin[AW-1:0];

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      wbin     <= '0;
      wgray    <= '0;
      full     <= 1'b0;
      overflow <= 1'b0;
    end else begin
      wbin  <= wbin_nx;
      wgray <= wgray_nx;
      full  <= full_nx;
      if (offer && full) overflow <= 1'b1;
    end
  end

  // R2: samples outside the visible window never advance the pointer
  p_blank_discard_r2: assert property (@(posedge wclk) disable iff (!wrst_n)
    !(pix_hact && pix_vact) |=> $stable(wgray));
  // R3: a viewable sample offered while full is not stored
  p_no_overwrite_r3: assert property (@(posedge wclk) disable iff (!wrst_n)
    (offer && full) |=> (wbin == $past(wbin)));
  // R4: overflow is sticky
  p_overflow_sticky_r4: assert property (@(posedge wclk) disable iff (!wrst_n)
    overflow |=> overflow);
  // R4: overflow only rises on a dropped sample
  p_overflow_cause_r4: assert property (@(posedge wclk) disable iff (!wrst_n)
    $rose(overflow) |-> $past(offer && full));
  // R1: Gray write pointer moves one bit at a time
  p_wgray_step_r1: assert property (@(posedge wclk) disable iff (!wrst_n)
    $countones(wgray ^ $past(wgray)) <= 1);
endmodule

// File: rtl/apf_rd_side.sv
module apf_rd_side #(
  parameter int unsigned AW = 9
) (
  input  logic          rclk,
  input  logic          rrst_n,
  input  logic          pop,
  input  logic [AW:0]   wgray_sync,
  output logic          fire,
  output logic [AW-1:0] raddr,
  output logic [AW:0]   rgray,
  output logic          empty
);
  logic [AW:0] rbin, rbin_nx, rgray_nx;

  assign fire     = pop & ~empty;
  assign rbin_nx  = rbin + {{AW{1'b0}}, fire};
  assign rgray_nx = (rbin_nx >> 1) ^ rbin_nx;
  assign raddr    = rbin[AW-1:0];

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rbin  <= '0;
      rgray <= '0;
      empty <= 1'b1;
    end else begin
      rbin  <= rbin_nx;
      rgray <= rgray_nx;
      empty <= (rgray_nx == wgray_sync);
    end
  end

  // R7: popping an empty FIFO leaves the read pointer alone
  p_pop_empty_hold_r7: assert property (@(posedge rclk) disable iff (!rrst_n)
    (empty && pop) |=> $stable(rgray));
  // R8: Gray read pointer moves one bit at a time
  p_rgray_step_r8: assert property (@(posedge rclk) disable iff (!rrst_n)
    $countones(rgray ^ $past(rgray)) <= 1);
endmodule

// File: rtl/active_pixel_cdc_fifo.sv
module active_pixel_cdc_fifo #(
  parameter int unsigned PIX_W = 20,
  parameter int unsigned DEPTH = 512
) (
  input  logic             wclk,
  input  logic             wrst_n,
  input  logic [PIX_W-1:0] pix_data,
  input  logic             pix_valid,
  input  logic             pix_hact,
  input  logic             pix_vact,
  output logic             line_active,
  output logic             field_active,
  output logic             wr_full,
  output logic             wr_overflow,
  input  logic             rclk,
  input  logic             rrst_n,
  input  logic             rd_pop,
  output logic [PIX_W-1:0] rd_data,
  output logic             rd_empty
);
  localparam int unsigned AW = $clog2(DEPTH);

  logic          push, fire;
  logic [AW-1:0] waddr, raddr;
  logic [AW:0]   wgray, rgray, wgray_s, rgray_s;

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      line_active  <= 1'b0;
      field_active <= 1'b0;
    end else begin
      line_active  <= pix_hact;
      field_active <= pix_vact;
    end
  end

  apf_wr_side #(.AW(AW)) u_wr (
    .wclk(wclk), .wrst_n(wrst_n), .pix_valid(pix_valid),
    .pix_hact(pix_hact), .pix_vact(pix_vact), .rgray_sync(rgray_s),
    .push(push), .waddr(waddr), .wgray(wgray),
    .full(wr_full), .overflow(wr_overflow)
  );

  apf_rd_side #(.AW(AW)) u_rd (
    .rclk(rclk), .rrst_n(rrst_n), .pop(rd_pop), .wgray_sync(wgray_s),
    .fire(fire), .raddr(raddr), .rgray(rgray), .empty(rd_empty)
  );

  apf_sync #(.W(AW+1)) u_w2r (.clk(rclk), .rst_n(rrst_n), .d(wgray), .q(wgray_s));
  apf_sync #(.W(AW+1)) u_r2w (.clk(wclk), .rst_n(wrst_n), .d(rgray), .q(rgray_s));

  apf_store #(.PIX_W(PIX_W), .AW(AW)) u_mem (
    .wclk(wclk), .we(push), .waddr(waddr), .wdata(pix_data),
    .rclk(rclk), .rrst_n(rrst_n), .re(fire), .raddr(raddr), .rdata(rd_data)
  );

  // R5: the write side never reports full while a write was just refused for another reason
  p_full_from_push_r5: assert property (@(posedge wclk) disable iff (!wrst_n)
    $rose(wr_full) |-> $past(push));
endmodule

// File: tb/active_pixel_cdc_fifo_bench.sv
module active_pixel_cdc_fifo_bench;
  logic        wclk = 0, rclk = 0, wrst_n = 0, rrst_n = 0;
  logic [19:0] pix_data = '0;
  logic        pix_valid = 0, pix_hact = 0, pix_vact = 0, rd_pop = 0;
  logic        line_active, field_active, wr_full, wr_overflow, rd_empty;
  logic [19:0] rd_data;
  int          n_chk = 0, n_bad = 0;

  always #2   wclk = ~wclk;  // 250 MHz
  always #3.5 rclk = ~rclk;

  active_pixel_cdc_fifo u_active_pixel_cdc_fifo (
    .wclk(wclk), .wrst_n(wrst_n), .pix_data(pix_data), .pix_valid(pix_valid),
    .pix_hact(pix_hact), .pix_vact(pix_vact), .line_active(line_active),
    .field_active(field_active), .wr_full(wr_full), .wr_overflow(wr_overflow),
    .rclk(rclk), .rrst_n(rrst_n), .rd_pop(rd_pop), .rd_data(rd_data),
    .rd_empty(rd_empty)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_px(input logic [19:0] d, input logic vl, input logic h, input logic v);
    @(negedge wclk);
    pix_data = d; pix_valid = vl; pix_hact = h; pix_vact = v;
    @(negedge wclk);
    pix_valid = 0;
  endtask

  task automatic settle();
    repeat (8) @(negedge rclk);
    repeat (8) @(negedge wclk);
  endtask

  task automatic pop_one(output logic [19:0] d);
    @(negedge rclk);
    rd_pop = 1;
    @(negedge rclk);
    d = rd_data;
    rd_pop = 0;
  endtask

  task automatic do_reset();
    wrst_n = 0; rrst_n = 0;
    repeat (3) @(negedge rclk);
    wrst_n = 1; rrst_n = 1;
    @(negedge wclk); @(negedge rclk);
  endtask

  task automatic t_reset_state();
    do_reset();
    chk("R10 empty", rd_empty, 1);
    chk("R10 full", wr_full, 0);
    chk("R10 overflow", wr_overflow, 0);
    chk("R10 rd_data", rd_data, 0);
    chk("R10 activity", {line_active, field_active}, 0);
  endtask

  task automatic t_order();
    logic [19:0] d;
    for (int i = 0; i < 5; i++) wr_px(20'h1000 + 20'(i * 17), 1, 1, 1);
    repeat (6) @(negedge rclk);
    chk("R6 empty falls", rd_empty, 0);
    for (int i = 0; i < 5; i++) begin
      pop_one(d);
      chk("R1 order", d, 20'h1000 + 20'(i * 17));
    end
    chk("R8 empty after last", rd_empty, 1);
  endtask

  task automatic t_gating();
    logic [19:0] d;
    wr_px(20'hA0001, 1, 1, 1);
    wr_px(20'hB0000, 1, 0, 1);
    wr_px(20'hC0000, 1, 1, 0);
    wr_px(20'hD0000, 0, 1, 1);
    wr_px(20'hA0002, 1, 1, 1);
    wr_px(20'hE0000, 1, 0, 0);
    wr_px(20'hA0003, 1, 1, 1);
    settle();
    for (int i = 1; i <= 3; i++) begin
      pop_one(d);
      chk("R2 only active kept", d, 20'hA0000 + 20'(i));
    end
    chk("R2 blanking discarded", rd_empty, 1);
  endtask

  task automatic t_pop_empty();
    logic [19:0] d;
    wr_px(20'h12345, 1, 1, 1);
    settle();
    pop_one(d);
    chk("R8 pop data", d, 20'h12345);
    pop_one(d);
    chk("R7 data held", d, 20'h12345);
    chk("R7 still empty", rd_empty, 1);
    wr_px(20'h00777, 1, 1, 1);
    settle();
    pop_one(d);
    chk("R7 pointer kept", d, 20'h00777);
  endtask

  task automatic t_fill();
    logic [19:0] d;
    for (int i = 0; i < 512; i++) begin
      if (i == 511) chk("R5 not full at 511", wr_full, 0);
      wr_px(20'(i * 3 + 5), 1, 1, 1);
    end
    chk("R5 full at 512", wr_full, 1);
    chk("R4 no overflow yet", wr_overflow, 0);
    for (int i = 0; i < 3; i++) wr_px(20'hFFFFF, 1, 1, 1);
    chk("R3 full held", wr_full, 1);
    chk("R4 overflow set", wr_overflow, 1);
    settle();
    pop_one(d);
    chk("R3 first intact", d, 20'd5);
    repeat (10) @(negedge wclk);
    chk("R11 full clears", wr_full, 0);
    for (int i = 1; i < 512; i++) begin
      pop_one(d);
      if (d !== 20'(i * 3 + 5)) chk("R1 R3 fill order", d, 20'(i * 3 + 5));
    end
    n_chk++;
    chk("R8 empty after drain", rd_empty, 1);
    chk("R4 overflow sticky", wr_overflow, 1);
  endtask

  task automatic t_activity();
    @(negedge wclk);
    pix_hact = 1; pix_vact = 0;
    @(negedge wclk);
    chk("R9 line on field off", {line_active, field_active}, 2'b10);
    pix_hact = 0; pix_vact = 1;
    @(negedge wclk);
    chk("R9 line off field on", {line_active, field_active}, 2'b01);
    pix_vact = 0;
  endtask

  task automatic t_reset_clears();
    do_reset();
    chk("R4 reset clears overflow", wr_overflow, 0);
    chk("R10 empty after reset", rd_empty, 1);
  endtask

  initial begin
    fork
      begin
        t_reset_state();
        t_order();
        t_gating();
        t_pop_empty();
        t_fill();
        t_activity();
        t_reset_clears();
      end
      begin
        repeat (150000) @(posedge wclk);
        chk("watchdog", 1, 0);
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule